// File: doc/BRIEF.md
# Two-Button Long-Push Recovery Detector

This block watches two active-low push-buttons, a power button and a recovery button, and recognizes a deliberate long hold of both together. The feature lets a user recover a system that has stopped responding. Both buttons must already be synchronized to the block clock. The hold is measured only while the system reports normal operation. It must last longer than the sum of three programmable cycle counts: a debounce time, a minimum interrupt time and an extra recovery delay. The extra delay may be zero.

A build-time option input selects what a recognized long push does:

- **Reset option:** the block raises a reset request for a programmable number of cycles. It also opens a confirmation window. If the host never raises its hold-confirm input during that window, the block issues a power-off request.
- **Power-off option:** the block issues a single-cycle power-off request straight away.

After it acts once, the detector stays locked until both buttons are up again.

Top module: `twin_hold_recovery`

## Requirements
- R1: While `rst` is high at a clock edge, `reset_pulse` and `power_off` are low after that edge.
- R2: Let L = `t_debounce` + `t_int_min` + `t_srd`. A long push is detected at the (L+1)-th consecutive rising edge that samples both buttons low with `run_mode` high. The chosen action shows on the outputs right after that edge, and both outputs stay low before it.
- R3: Detection works the same whichever button went low first; the count starts only when the second one goes low.
- R4: If either button is released before detection, nothing happens. The count restarts from zero at the next press of both buttons.
- R5: Any of the three delay counts may be zero. With all three at zero, detection happens at the first edge that samples both buttons low.
- R6: With `opt_reset` = 1, `reset_pulse` is high for exactly `t_recover` cycles, starting in the cycle after detection. A `t_recover` of 0 gives no pulse.
- R7: With `opt_reset` = 1, a confirmation window covers the `t_blank`+1 rising edges after detection. If `hold_in` is low at every one of them, `power_off` is high for one cycle after the last of them. If `hold_in` is high at any of them, `power_off` stays low.
- R8: With `opt_reset` = 0, `power_off` is high for exactly one cycle right after detection, and `reset_pulse` stays low.
- R9: While `run_mode` is low, a hold of both buttons is not counted and produces no action.
- R10: After a detection, no further detection occurs until both buttons have been sampled high together, even if both stay held or one is released and pressed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_btn_n | input | 1 | Power button, active low, synchronized |
| sr_btn_n | input | 1 | Recovery button, active low, synchronized |
| run_mode | input | 1 | High while the system is in normal operation |
| opt_reset | input | 1 | 1 = reset-pulse action, 0 = power-off action |
| hold_in | input | 1 | Host confirmation level checked in the confirmation window |
| t_debounce | input | CNT_W | Debounce time in cycles |
| t_int_min | input | CNT_W | Minimum interrupt time in cycles |
| t_srd | input | CNT_W | Extra recovery delay in cycles, may be 0 |
| t_recover | input | CNT_W | Length of the reset request in cycles |
| t_blank | input | CNT_W | Confirmation window length minus one, in cycles |
| reset_pulse | output | 1 | Registered reset request |
| power_off | output | 1 | Registered one-cycle power-off request |

## Verification
The bench sweeps every combination of the three delay counts from 0 to 2, with both options and both press orders. For each case it checks that the outputs stay low up to the last cycle before the computed limit and change exactly one cycle later. This separates off-by-one errors in the limit from errors in the order handling.

An early-release sweep lets go of one button at the last cycle before detection and then presses again. This shows that the count is cancelled and restarts from zero rather than resuming.

Directed cases cover the rest:
- the confirmation window with `hold_in` never raised, and with it raised briefly;
- a zero recovery length;
- `run_mode` low;
- re-pressing a single button after a detection.

These expose a misplaced window end, a missing hold latch and a lock that clears too early.

// File: rtl/twin_hold_pkg.sv
package twin_hold_pkg;
  typedef enum logic {
    ACT_POWER_OFF = 1'b0,
    ACT_RESET     = 1'b1
  } action_e;
endpackage

// File: rtl/twin_hold_timer.sv
module twin_hold_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_btn_n,
  input  logic             sr_btn_n,
  input  logic             run_mode,
  input  logic [CNT_W-1:0] t_debounce,
  input  logic [CNT_W-1:0] t_int_min,
  input  logic [CNT_W-1:0] t_srd,
  output logic             fire
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] STEP = SUM_W'(1);

  logic [SUM_W-1:0] limit;
  logic [SUM_W-1:0] held;
  logic             locked;
  logic             both_low;
  logic             both_up;
  logic             qualify;

  always_comb begin
    limit    = SUM_W'(t_debounce) + SUM_W'(t_int_min) + SUM_W'(t_srd);
    both_low = !pwr_btn_n && !sr_btn_n;
    both_up  = pwr_btn_n && sr_btn_n;
    qualify  = both_low && run_mode && !locked;
    fire     = qualify && (held == limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= '0;
      locked <= 1'b0;
    end else begin
      if (both_up) locked <= 1'b0;
      if (!qualify) begin
        held <= '0;
      end else if (fire) begin
        held   <= '0;
        locked <= 1'b1;
      end else begin
        held <= held + STEP;
      end
    end
  end
endmodule

// File: rtl/twin_hold_action.sv
module twin_hold_action #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             reset_mode,
  input  logic             hold_in,
  input  logic [CNT_W-1:0] t_recover,
  input  logic [CNT_W-1:0] t_blank,
  output logic             reset_pulse,
  output logic             power_off
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rec_left;
  logic [CNT_W-1:0] blank_left;
  logic             blank_on;
  logic             hold_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_pulse <= 1'b0;
      power_off   <= 1'b0;
      rec_left    <= '0;
      blank_left  <= '0;
      blank_on    <= 1'b0;
      hold_seen   <= 1'b0;
    end else begin
      power_off <= 1'b0;
      if (fire && reset_mode) begin
        reset_pulse <= (t_recover != '0);
        rec_left    <= t_recover - ONE;
        blank_on    <= 1'b1;
        blank_left  <= t_blank;
        hold_seen   <= 1'b0;
      end else begin
        if (reset_pulse) begin
          if (rec_left == '0) reset_pulse <= 1'b0;
          else                rec_left    <= rec_left - ONE;
        end
        if (blank_on) begin
          if (hold_in) hold_seen <= 1'b1;
          if (blank_left == '0) begin
            blank_on <= 1'b0;
            if (!(hold_seen || hold_in)) power_off <= 1'b1;
          end else begin
            blank_left <= blank_left - ONE;
          end
        end
      end
      if (fire && !reset_mode) power_off <= 1'b1;
    end
  end
endmodule

// File: rtl/twin_hold_recovery.sv
module twin_hold_recovery
  import twin_hold_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_btn_n,
  input  logic             sr_btn_n,
  input  logic             run_mode,
  input  logic             opt_reset,
  input  logic             hold_in,
  input  logic [CNT_W-1:0] t_debounce,
  input  logic [CNT_W-1:0] t_int_min,
  input  logic [CNT_W-1:0] t_srd,
  input  logic [CNT_W-1:0] t_recover,
  input  logic [CNT_W-1:0] t_blank,
  output logic             reset_pulse,
  output logic             power_off
);
  logic    fire;
  action_e act_sel;
  logic    reset_mode;

  always_comb begin
    act_sel    = action_e'(opt_reset);
    reset_mode = (act_sel == ACT_RESET);
  end

  twin_hold_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .pwr_btn_n  (pwr_btn_n),
    .sr_btn_n   (sr_btn_n),
    .run_mode   (run_mode),
    .t_debounce (t_debounce),
    .t_int_min  (t_int_min),
    .t_srd      (t_srd),
    .fire       (fire)
  );

  twin_hold_action #(.CNT_W(CNT_W)) u_action (
    .clk         (clk),
    .rst         (rst),
    .fire        (fire),
    .reset_mode  (reset_mode),
    .hold_in     (hold_in),
    .t_recover   (t_recover),
    .t_blank     (t_blank),
    .reset_pulse (reset_pulse),
    .power_off   (power_off)
  );
endmodule

// File: rtl/twin_hold_recovery_chk.sv
module twin_hold_recovery_chk (
  input logic clk,
  input logic rst,
  input logic pwr_btn_n,
  input logic sr_btn_n,
  input logic run_mode,
  input logic opt_reset,
  input logic reset_pulse,
  input logic power_off
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!reset_pulse && !power_off));

  // R2
  rise_needs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_pulse) |-> $past(!pwr_btn_n && !sr_btn_n));

  // R6
  reset_opt_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_pulse) |-> $past(opt_reset));

  // R8
  poweroff_single_chk: assert property (@(posedge clk) disable iff (rst)
    power_off |=> !power_off);

  // R8
  poweroff_direct_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(power_off) && !$past(opt_reset)) |-> $past(!pwr_btn_n && !sr_btn_n && run_mode));

  // R9
  run_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_pulse) |-> $past(run_mode));
endmodule

bind twin_hold_recovery twin_hold_recovery_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .pwr_btn_n   (pwr_btn_n),
  .sr_btn_n    (sr_btn_n),
  .run_mode    (run_mode),
  .opt_reset   (opt_reset),
  .reset_pulse (reset_pulse),
  .power_off   (power_off)
);

// File: tb/twin_hold_recovery_bench.sv
module twin_hold_recovery_bench;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwr_btn_n = 1'b1;
  logic          sr_btn_n = 1'b1;
  logic          run_mode = 1'b1;
  logic          opt_reset = 1'b0;
  logic          hold_in = 1'b1;
  logic [CW-1:0] t_debounce = '0;
  logic [CW-1:0] t_int_min = '0;
  logic [CW-1:0] t_srd = '0;
  logic [CW-1:0] t_recover = 8'd2;
  logic [CW-1:0] t_blank = 8'd3;
  logic          reset_pulse;
  logic          power_off;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  twin_hold_recovery #(.CNT_W(CW)) u_twin_hold_recovery (
    .clk(clk), .rst(rst), .pwr_btn_n(pwr_btn_n), .sr_btn_n(sr_btn_n),
    .run_mode(run_mode), .opt_reset(opt_reset), .hold_in(hold_in),
    .t_debounce(t_debounce), .t_int_min(t_int_min), .t_srd(t_srd),
    .t_recover(t_recover), .t_blank(t_blank),
    .reset_pulse(reset_pulse), .power_off(power_off)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic quiet(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk({req, " reset_pulse"}, reset_pulse, 1'b0);
      chk({req, " power_off"}, power_off, 1'b0);
    end
  endtask

  task automatic release_all();
    pwr_btn_n = 1'b1;
    sr_btn_n  = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic press_both(input bit pwr_first);
    if (pwr_first) pwr_btn_n = 1'b0; else sr_btn_n = 1'b0;
    @(negedge clk);
    chk("R3 single button reset_pulse", reset_pulse, 1'b0);
    chk("R3 single button power_off", power_off, 1'b0);
    @(negedge clk);
    pwr_btn_n = 1'b0;
    sr_btn_n  = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset_pulse", reset_pulse, 1'b0);
    chk("R1 power_off", power_off, 1'b0);
    rst = 1'b0;
    quiet("R1 idle", 2);

    // R2 R3 R5 R6 R8 sweep over delays, options and press order
    for (int d = 0; d < 3; d++)
      for (int i = 0; i < 3; i++)
        for (int s = 0; s < 3; s++)
          for (int o = 0; o < 2; o++)
            for (int ord = 0; ord < 2; ord++) begin
              int total;
              total      = d + i + s;
              t_debounce = CW'(d);
              t_int_min  = CW'(i);
              t_srd      = CW'(s);
              opt_reset  = o[0];
              t_recover  = 8'd2;
              t_blank    = 8'd3;
              hold_in    = 1'b1;
              press_both(ord[0]);
              quiet("R2/R3/R5 before limit", total);
              @(negedge clk);
              if (o == 1) begin
                chk("R2/R6 reset_pulse at detection", reset_pulse, 1'b1);
                chk("R6 power_off at detection", power_off, 1'b0);
                @(negedge clk);
                chk("R6 reset_pulse second cycle", reset_pulse, 1'b1);
                @(negedge clk);
                chk("R6 reset_pulse end", reset_pulse, 1'b0);
              end else begin
                chk("R2/R8 power_off at detection", power_off, 1'b1);
                chk("R8 reset_pulse stays low", reset_pulse, 1'b0);
                @(negedge clk);
                chk("R8 power_off single cycle", power_off, 1'b0);
                @(negedge clk);
              end
              quiet("R7/R10 held after detection", 5);
              release_all();
            end

    // R4 early release, then restart from zero
    opt_reset = 1'b0;
    for (int d = 0; d < 3; d++)
      for (int s = 0; s < 3; s++)
        for (int ord = 0; ord < 2; ord++) begin
          int total;
          total      = d + 1 + s;
          t_debounce = CW'(d);
          t_int_min  = 8'd1;
          t_srd      = CW'(s);
          press_both(ord[0]);
          repeat (total) @(negedge clk);
          if (ord == 1) pwr_btn_n = 1'b1; else sr_btn_n = 1'b1;
          quiet("R4 after early release", total + 3);
          pwr_btn_n = 1'b0;
          sr_btn_n  = 1'b0;
          quiet("R4 restarted count", total);
          @(negedge clk);
          chk("R4 fires after full restart", power_off, 1'b1);
          release_all();
        end

    // R6 zero recovery length gives no pulse
    opt_reset = 1'b1; t_recover = 8'd0; t_blank = 8'd2; hold_in = 1'b1;
    t_debounce = 8'd1; t_int_min = 8'd0; t_srd = 8'd0;
    press_both(1'b1);
    quiet("R6 zero recover", 8);
    release_all();

    // R7 window expires without confirmation
    t_recover = 8'd1; t_blank = 8'd4; hold_in = 1'b0;
    press_both(1'b0);
    @(negedge clk);
    for (int j = 0; j <= 7; j++) begin
      @(negedge clk);
      chk("R7 unconfirmed power_off", power_off, j == 5);
    end
    release_all();

    // R7 brief confirmation inside the window
    hold_in = 1'b0;
    press_both(1'b1);
    @(negedge clk);
    for (int j = 0; j <= 7; j++) begin
      @(negedge clk);
      hold_in = (j == 2);
      chk("R7 confirmed power_off", power_off, 1'b0);
    end
    hold_in = 1'b1;
    release_all();

    // R9 run_mode low blocks detection
    run_mode = 1'b0; opt_reset = 1'b0;
    press_both(1'b1);
    quiet("R9 run_mode low", 20);
    release_all();
    run_mode = 1'b1;

    // R10 lock until both released
    t_debounce = 8'd1; t_int_min = 8'd0; t_srd = 8'd0;
    press_both(1'b1);
    @(negedge clk);
    @(negedge clk);
    chk("R10 first detection", power_off, 1'b1);
    quiet("R10 still held", 10);
    pwr_btn_n = 1'b1;
    quiet("R10 one released", 2);
    pwr_btn_n = 1'b0;
    quiet("R10 re-pressed single", 10);
    release_all();
    pwr_btn_n = 1'b0; sr_btn_n = 1'b0;
    quiet("R10 after full release", 1);
    @(negedge clk);
    chk("R10 detects again", power_off, 1'b1);
    release_all();

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule